// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a virtual-to-real page translation by searching a hashed page table held in ordinary memory. A requester hands it the fields of the active segment descriptor (virtual segment identifier, the supervisor and user protection keys, the no-execute flag), the low 28 bits of the effective address and the kind of access. The walker hashes the segment identifier with the page index and scans a primary group of eight entries. If that fails, it scans a secondary group addressed by the complemented hash. On a match it checks page protection and sets the referenced and changed bytes in memory where needed. It then reports the real address and the granted permissions.

Memory is reached through a 32-bit read port and a byte-write port. A read is a one-cycle request pulse, and its data returns with a valid strobe in any later cycle. Byte addresses are big-endian: byte 0 of a word is bits 31:24. The table base and size mask come in as static configuration inputs. Pages are always 4 KiB.

Top module: `hpt_walker`

## Requirements
- R1: A request is taken when `req_valid` is high while `busy` is low. `busy` stays high until the walk ends. `done` is a single-cycle pulse, and with it exactly one of `hit`, `miss`, `fault` is high.
- R2: The hash is the 24-bit VSID XOR the zero-extended page index `ea[27:12]`. The primary group address is `tbl_base + ((hash << 6) & tbl_mask)`. The secondary group address uses the bitwise complement of the 32-bit zero-extended hash in place of the hash. `tbl_base` is 64-byte aligned.
- R3: Entry word 0 holds the valid flag in bit 31, the VSID in bits 30:7, the pass flag H in bit 6 and `ea[27:22]` in bits 5:0. An entry matches only if it is valid, its H equals the pass (0 primary, 1 secondary) and both tag fields are equal.
- R4: The eight entries of a group are scanned from the lowest address upward, the primary group before the secondary. The first matching entry wins.
- R5: Word 0 of an entry is read before word 1 (at entry + 4). Word 1 is read only for the matching entry.
- R6: The key is `key_user` for user accesses and `key_sup` otherwise. The protection code is word 1 bits 1:0. With key 0, codes 0, 1 and 2 give read/write and code 3 gives read-only. With key 1, code 0 gives nothing, code 2 gives read/write, and codes 1 and 3 give read-only.
- R7: Execute permission equals read permission unless `seg_nx` is set, in which case execute is withheld.
- R8: A load needs read, a store needs write and a fetch needs execute. Otherwise the result is `fault` and no byte is written.
- R9: When the referenced bit (word 1 bit 8) is clear, the walker writes byte entry + 6 with word 1 bits 15:8 ORed with 0x01. This write comes before any changed-bit write.
- R10: When the changed bit (word 1 bit 7) is clear, a store writes byte entry + 7 with word 1 bits 7:0 ORed with 0x80. Any other access type has write permission removed from its result instead.
- R11: On a hit, `res_pa` is word 1 bits 31:12 followed by `ea[11:0]`.
- R12: When neither group holds a matching entry, the result is `miss` after sixteen word-0 reads, and no byte is written.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk |
| req_vsid | input | 24 | Virtual segment identifier |
| key_sup | input | 1 | Protection key for supervisor accesses |
| key_user | input | 1 | Protection key for user accesses |
| seg_nx | input | 1 | Segment no-execute flag |
| req_ea | input | 28 | Effective address within the segment |
| req_user | input | 1 | Access is from user state |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| tbl_base | input | 32 | Table base byte address |
| tbl_mask | input | 32 | Group offset mask |
| mem_rd_req | output | 1 | Read request pulse |
| mem_rd_addr | output | 32 | Read word address |
| mem_rd_valid | input | 1 | Read data strobe |
| mem_rd_data | input | 32 | Read data |
| mem_wr_en | output | 1 | Byte write strobe |
| mem_wr_addr | output | 32 | Byte write address |
| mem_wr_data | output | 8 | Byte write data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Result valid pulse |
| hit | output | 1 | Translation found and allowed |
| miss | output | 1 | No matching entry |
| fault | output | 1 | Matching entry denies the access |
| res_pa | output | 32 | Real address |
| res_r | output | 1 | Read granted |
| res_w | output | 1 | Write granted |
| res_x | output | 1 | Execute granted |

## Verification
The bench places decoy entries ahead of the real one: an entry with its valid flag clear, one with the wrong H flag, one with a wrong tag, and a second matching entry further down the group. A walker that ignored any of these fields, or that did not stop at the first match, would read a different address sequence or return the wrong page. Secondary-group hits are tried under a narrow mask. A walker that complemented after masking, or that shifted the complement wrongly, would fetch from the wrong group. The bench also covers a fault on an entry whose referenced bit is clear, which catches a walker that writes back before the permission check. It covers a load on a page whose changed bit is clear, which catches a walker that still grants write.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SCAN,
    ST_WORD1,
    ST_CHECK,
    ST_SETC,
    ST_FIN
  } walk_st_t;

  typedef struct packed {
    logic r;
    logic w;
  } rw_t;

  // key/code to read-write rights
  function automatic rw_t pp_decode(input logic key, input logic [1:0] pp);
    rw_t o;
    o.r = !(key && (pp == 2'd0));
    o.w = key ? (pp == 2'd2) : (pp != 2'd3);
    return o;
  endfunction

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int AW        = 32,
  parameter int VSID_W    = 24,
  parameter int PG_W      = 16,
  parameter int API_W     = 6,
  parameter int GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0]       vsid,
  input  logic [PG_W-1:0]         pgidx,
  input  logic [AW-1:0]           base,
  input  logic [AW-1:0]           mask,
  output logic [AW-1:0]           grp_pri,
  output logic [AW-1:0]           grp_sec,
  output logic [VSID_W+API_W-1:0] tag
);
  logic [VSID_W-1:0] h_small;
  logic [AW-1:0]     h;

  assign h_small = vsid ^ VSID_W'(pgidx);
  assign h       = AW'(h_small);
  assign grp_pri = base + ((h << GRP_SHIFT) & mask);
  assign grp_sec = base + (((~h) << GRP_SHIFT) & mask);
  assign tag     = {vsid, pgidx[PG_W-1 -: API_W]};
endmodule

// File: rtl/hpt_prot.sv
module hpt_prot
  import hpt_pkg::*;
(
  input  logic [1:0] pp,
  input  logic       key,
  input  logic       nx,
  output logic       pr,
  output logic       pw,
  output logic       px
);
  rw_t d;
  always_comb d = pp_decode(key, pp);
  assign pr = d.r;
  assign pw = d.w;
  assign px = d.r && !nx;

  always_comb begin
    // R7: execute never granted without read
    a_r7_exec_needs_read: assert (!px || pr) else $error("exec without read");
    // R6: key 1 with code 0 grants nothing
    a_r6_key1_code0_none: assert (!(key && pp == 2'd0) || (!pr && !pw))
      else $error("key1 code0 grants access");
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int SLOTS = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [23:0] req_vsid,
  input  logic        key_sup,
  input  logic        key_user,
  input  logic        seg_nx,
  input  logic [27:0] req_ea,
  input  logic        req_user,
  input  logic        req_store,
  input  logic        req_fetch,
  input  logic [31:0] tbl_base,
  input  logic [31:0] tbl_mask,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_valid,
  input  logic [31:0] mem_rd_data,
  output logic        mem_wr_en,
  output logic [31:0] mem_wr_addr,
  output logic [7:0]  mem_wr_data,
  output logic        busy,
  output logic        done,
  output logic        hit,
  output logic        miss,
  output logic        fault,
  output logic [31:0] res_pa,
  output logic        res_r,
  output logic        res_w,
  output logic        res_x
);
  localparam int IDX_W     = $clog2(SLOTS);
  localparam int ENT_BYTES = 8;
  localparam int GRP_SHIFT = $clog2(SLOTS * ENT_BYTES);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  walk_st_t     st;
  logic [23:0]  vsid_q;
  logic [15:0]  pg_q;
  logic [11:0]  off_q;
  logic         ks_q, kp_q, nx_q, user_q, store_q, fetch_q;
  logic         pass_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]  ent_q;
  logic [31:0]  w1_q;

  logic [31:0]  grp_pri, grp_sec;
  logic [29:0]  tag;
  logic         pr, pw, px, key, allow, match;

  hpt_hash #(.AW(32), .VSID_W(24), .PG_W(16), .API_W(6), .GRP_SHIFT(GRP_SHIFT)) u_hash (
    .vsid(vsid_q), .pgidx(pg_q), .base(tbl_base), .mask(tbl_mask),
    .grp_pri(grp_pri), .grp_sec(grp_sec), .tag(tag)
  );

  assign key = user_q ? kp_q : ks_q;

  hpt_prot u_prot (.pp(w1_q[1:0]), .key(key), .nx(nx_q), .pr(pr), .pw(pw), .px(px));

  assign allow = fetch_q ? px : (store_q ? pw : pr);
  assign match = mem_rd_data[31] && (mem_rd_data[6] == pass_q) &&
                 ({mem_rd_data[30:7], mem_rd_data[5:0]} == tag);
  assign busy  = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      vsid_q <= '0; pg_q <= '0; off_q <= '0;
      ks_q <= 1'b0; kp_q <= 1'b0; nx_q <= 1'b0;
      user_q <= 1'b0; store_q <= 1'b0; fetch_q <= 1'b0;
      pass_q <= 1'b0; idx_q <= '0; ent_q <= '0; w1_q <= '0;
      mem_rd_req <= 1'b0; mem_rd_addr <= '0;
      mem_wr_en <= 1'b0; mem_wr_addr <= '0; mem_wr_data <= '0;
      done <= 1'b0; hit <= 1'b0; miss <= 1'b0; fault <= 1'b0;
      res_pa <= '0; res_r <= 1'b0; res_w <= 1'b0; res_x <= 1'b0;
    end else begin
      done       <= 1'b0;
      mem_rd_req <= 1'b0;
      mem_wr_en  <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          vsid_q <= req_vsid; pg_q <= req_ea[27:12]; off_q <= req_ea[11:0];
          ks_q <= key_sup; kp_q <= key_user; nx_q <= seg_nx;
          user_q <= req_user; store_q <= req_store; fetch_q <= req_fetch;
          st <= ST_START;
        end
        ST_START: begin
          pass_q <= 1'b0; idx_q <= '0;
          ent_q <= grp_pri;
          mem_rd_req <= 1'b1; mem_rd_addr <= grp_pri;
          st <= ST_SCAN;
        end
        ST_SCAN: if (mem_rd_valid) begin
          if (match) begin
            mem_rd_req <= 1'b1; mem_rd_addr <= ent_q + 32'd4;
            st <= ST_WORD1;
          end else if (idx_q != LAST) begin
            idx_q <= idx_q + 1'b1;
            ent_q <= ent_q + 32'(ENT_BYTES);
            mem_rd_req <= 1'b1; mem_rd_addr <= ent_q + 32'(ENT_BYTES);
          end else if (!pass_q) begin
            pass_q <= 1'b1; idx_q <= '0;
            ent_q <= grp_sec;
            mem_rd_req <= 1'b1; mem_rd_addr <= grp_sec;
          end else begin
            done <= 1'b1; hit <= 1'b0; miss <= 1'b1; fault <= 1'b0;
            st <= ST_IDLE;
          end
        end
        ST_WORD1: if (mem_rd_valid) begin
          w1_q <= mem_rd_data;
          st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!allow) begin
            done <= 1'b1; hit <= 1'b0; miss <= 1'b0; fault <= 1'b1;
            res_pa <= {w1_q[31:12], off_q};
            res_r <= pr; res_w <= pw; res_x <= px;
            st <= ST_IDLE;
          end else begin
            if (!w1_q[8]) begin
              mem_wr_en <= 1'b1; mem_wr_addr <= ent_q + 32'd6;
              mem_wr_data <= w1_q[15:8] | 8'h01;
            end
            st <= ST_SETC;
          end
        end
        ST_SETC: begin
          if (!w1_q[7] && store_q) begin
            mem_wr_en <= 1'b1; mem_wr_addr <= ent_q + 32'd7;
            mem_wr_data <= w1_q[7:0] | 8'h80;
          end
          st <= ST_FIN;
        end
        ST_FIN: begin
          done <= 1'b1; hit <= 1'b1; miss <= 1'b0; fault <= 1'b0;
          res_pa <= {w1_q[31:12], off_q};
          res_r <= pr; res_x <= px;
          res_w <= pw && (w1_q[7] || store_q);
          st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: single-cycle result pulse with one outcome
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r1_one_outcome: assert property (@(posedge clk) disable iff (rst)
    done |-> $countones({hit, miss, fault}) == 1);
  // R5: a word-1 read only follows returned word-0 data
  a_r5_word_order: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && mem_rd_addr[2]) |-> $past(mem_rd_valid));
  // R8: a fault leaves memory untouched
  a_r8_no_wb_on_fault: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> !$past(mem_wr_en));
  // R12: a miss leaves memory untouched
  a_r12_no_wb_on_miss: assert property (@(posedge clk) disable iff (rst)
    (done && miss) |-> !$past(mem_wr_en));
  // R11: page offset passes through
  a_r11_page_offset: assert property (@(posedge clk) disable iff (rst)
    (done && hit) |-> res_pa[11:0] == off_q);
endmodule

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [23:0] req_vsid = '0;
  logic        key_sup = 1'b0, key_user = 1'b0, seg_nx = 1'b0;
  logic [27:0] req_ea = '0;
  logic        req_user = 1'b0, req_store = 1'b0, req_fetch = 1'b0;
  logic [31:0] tbl_base = 32'h0010_0000, tbl_mask = 32'h000F_FFC0;
  logic        mem_rd_req, mem_wr_en;
  logic [31:0] mem_rd_addr, mem_wr_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic [7:0]  mem_wr_data;
  logic        busy, done, hit, miss, fault, res_r, res_w, res_x;
  logic [31:0] res_pa;

  hpt_walker dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vsid(req_vsid),
    .key_sup(key_sup), .key_user(key_user), .seg_nx(seg_nx), .req_ea(req_ea),
    .req_user(req_user), .req_store(req_store), .req_fetch(req_fetch),
    .tbl_base(tbl_base), .tbl_mask(tbl_mask),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .busy(busy), .done(done), .hit(hit), .miss(miss), .fault(fault),
    .res_pa(res_pa), .res_r(res_r), .res_w(res_w), .res_x(res_x)
  );

  int checks = 0;
  int errors = 0;
  bit [31:0] mem [bit [31:0]];
  bit [31:0] rdq [$];
  bit [39:0] wrq [$];

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic bit [31:0] rdw(input bit [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder and per-cycle stream comparison
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (!rst && mem_rd_req) begin
      chk(rdq.size() > 0 && rdq[0] == mem_rd_addr, "R4 R5 read sequence",
          mem_rd_addr, rdq.size() > 0 ? rdq[0] : 32'hFFFF_FFFF);
      if (rdq.size() > 0) void'(rdq.pop_front());
      mem_rd_valid = 1'b1;
      mem_rd_data  = rdw(mem_rd_addr);
    end
    if (!rst && mem_wr_en) begin
      bit [31:0] wa, w;
      int k;
      chk(wrq.size() > 0 && wrq[0] == {mem_wr_addr, mem_wr_data}, "R9 R10 byte write",
          {mem_wr_addr[23:0], mem_wr_data}, wrq.size() > 0 ? wrq[0][31:0] : 32'hFFFF_FFFF);
      if (wrq.size() > 0) void'(wrq.pop_front());
      wa = {mem_wr_addr[31:2], 2'b00};
      k  = int'(mem_wr_addr[1:0]);
      w  = rdw(wa);
      w[8*(3-k) +: 8] = mem_wr_data;
      mem[wa] = w;
    end
  end

  function automatic bit [31:0] grp(input bit [23:0] vsid, input bit [27:0] ea, input bit p);
    bit [31:0] h;
    h = {8'h00, vsid ^ {8'h00, ea[27:12]}};
    if (p) h = ~h;
    return tbl_base + ((h << 6) & tbl_mask);
  endfunction

  function automatic bit [31:0] mk0(input bit v, input bit [23:0] vsid, input bit [27:0] ea, input bit h);
    return {v, vsid, h, ea[27:22]};
  endfunction

  function automatic bit [31:0] mk1(input bit [19:0] rpn, input bit r, input bit c, input bit [1:0] pp);
    return {rpn, 3'b000, r, c, 5'b00000, pp};
  endfunction

  task automatic put(input bit [31:0] a, input bit [31:0] w0, input bit [31:0] w1);
    mem[a] = w0;
    mem[a + 4] = w1;
  endtask

  // behavioural reference walk, then drive and compare
  task automatic run(input string nm, input bit [23:0] vsid, input bit ks, input bit kp,
                     input bit nx, input bit [27:0] ea, input bit user, input bit store,
                     input bit fetch);
    bit found = 0;
    bit [31:0] ent = 0, w0, w1 = 0, pa;
    bit r, w, x, ok, key;
    int kind;  // 0 hit, 1 miss, 2 fault
    int n;
    for (int p = 0; p < 2 && !found; p++) begin
      for (int i = 0; i < 8 && !found; i++) begin
        bit [31:0] a;
        a = grp(vsid, ea, p[0]) + 32'(i * 8);
        rdq.push_back(a);
        w0 = rdw(a);
        if (w0[31] && w0[6] == p[0] && w0[30:7] == vsid && w0[5:0] == ea[27:22]) begin
          found = 1;
          ent = a;
          rdq.push_back(a + 4);
          w1 = rdw(a + 4);
        end
      end
    end
    key = user ? kp : ks;
    case (w1[1:0])
      2'd0: begin r = !key; w = !key; end
      2'd1: begin r = 1;    w = !key; end
      2'd2: begin r = 1;    w = 1;    end
      default: begin r = 1; w = 0;    end
    endcase
    x  = r & !nx;
    ok = fetch ? x : (store ? w : r);
    pa = {w1[31:12], ea[11:0]};
    if (!found) kind = 1;
    else if (!ok) kind = 2;
    else begin
      kind = 0;
      if (!w1[8]) wrq.push_back({ent + 32'd6, w1[15:8] | 8'h01});
      if (!w1[7]) begin
        if (store) wrq.push_back({ent + 32'd7, w1[7:0] | 8'h80});
        else w = 0;
      end
    end

    @(negedge clk);
    chk(!busy, {nm, " R1 idle before request"}, 32'(busy), 0);
    req_vsid = vsid; key_sup = ks; key_user = kp; seg_nx = nx; req_ea = ea;
    req_user = user; req_store = store; req_fetch = fetch; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy, {nm, " R1 busy after accept"}, 32'(busy), 1);
    n = 0;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(done, {nm, " R1 done seen"}, 32'(done), 1);
    chk({hit, miss, fault} == {kind == 0, kind == 1, kind == 2}, {nm, " R1 R8 R12 outcome"},
        32'({hit, miss, fault}), 32'({kind == 0, kind == 1, kind == 2}));
    if (kind == 0) begin
      chk(res_pa == pa, {nm, " R11 real address"}, res_pa, pa);
      chk({res_r, res_w, res_x} == {r, w, x}, {nm, " R6 R7 R10 rights"},
          32'({res_r, res_w, res_x}), 32'({r, w, x}));
    end
    chk(rdq.size() == 0, {nm, " R4 R12 all reads issued"}, rdq.size(), 0);
    chk(wrq.size() == 0, {nm, " R8 R9 R10 all writes issued"}, wrq.size(), 0);
    rdq.delete();
    wrq.delete();
    @(negedge clk);
    chk(!done && !busy, {nm, " R1 pulse ends"}, 32'({done, busy}), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit [23:0] v;
    bit [27:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({busy, done, mem_rd_req, mem_wr_en} == 4'b0, "R1 reset state",
        32'({busy, done, mem_rd_req, mem_wr_en}), 0);

    // R9 R10: store, both bits clear, two writes in order
    mem.delete();
    v = 24'h00_1357; e = 28'h123_4ABC;
    put(grp(v, e, 0), mk0(1, v, e, 0), mk1(20'hABCDE, 0, 0, 2'd2));
    run("T1", v, 0, 0, 0, e, 0, 1, 0);

    // R3 R4 R10: decoys before slot 5, load with changed clear
    mem.delete();
    v = 24'h000ABC; e = 28'h9876_543;
    put(grp(v, e, 0) + 0,  mk0(0, v, e, 0), mk1(20'h11111, 1, 1, 2'd2));
    put(grp(v, e, 0) + 8,  mk0(1, v, e, 1), mk1(20'h22222, 1, 1, 2'd2));
    put(grp(v, e, 0) + 16, mk0(1, v + 1, e, 0), mk1(20'h33333, 1, 1, 2'd2));
    put(grp(v, e, 0) + 40, mk0(1, v, e, 0), mk1(20'h55555, 1, 0, 2'd0));
    run("T2", v, 0, 0, 0, e, 0, 0, 0);

    // R2 R3 R4: secondary hit, skipping an H=0 match in the secondary group
    mem.delete();
    v = 24'h4455AA; e = 28'h0F0_F123;
    put(grp(v, e, 1) + 8,  mk0(1, v, e, 0), mk1(20'h0DEAD, 1, 1, 2'd2));
    put(grp(v, e, 1) + 24, mk0(1, v, e, 1), mk1(20'h0BEEF, 1, 0, 2'd1));
    run("T3", v, 0, 0, 0, e, 0, 1, 0);

    // R12: miss
    mem.delete();
    run("T4", 24'h777777, 0, 0, 0, 28'h555_5555, 0, 0, 0);

    // R6 R8: user key 1, code 0, load faults with referenced clear
    mem.delete();
    v = 24'h012345; e = 28'h2AA_A777;
    put(grp(v, e, 0) + 16, mk0(1, v, e, 0), mk1(20'h12121, 0, 0, 2'd0));
    run("T5", v, 0, 1, 0, e, 1, 0, 0);

    // R6 R8: supervisor key 1, code 3, store faults
    mem.delete();
    v = 24'h0F00F0; e = 28'h100_0000;
    put(grp(v, e, 0), mk0(1, v, e, 0), mk1(20'h34343, 0, 0, 2'd3));
    run("T6", v, 1, 0, 0, e, 0, 1, 0);

    // R7 R8: fetch with no-execute faults, then without it hits
    mem.delete();
    v = 24'h00C0DE; e = 28'h321_0FFF;
    put(grp(v, e, 0) + 56, mk0(1, v, e, 0), mk1(20'h56565, 0, 1, 2'd2));
    run("T7", v, 0, 0, 1, e, 0, 0, 1);
    run("T8", v, 0, 0, 0, e, 0, 0, 1);

    // R9 R10: both bits set, store, no writes
    mem.delete();
    v = 24'hA0A0A0; e = 28'h0AB_C010;
    put(grp(v, e, 0) + 8, mk0(1, v, e, 0), mk1(20'h78787, 1, 1, 2'd2));
    run("T9", v, 0, 0, 0, e, 0, 1, 0);

    // R2 R6: narrow mask, other base, secondary, user key 1 code 1 load
    mem.delete();
    tbl_base = 32'h0040_0000; tbl_mask = 32'h0000_FFC0;
    v = 24'hFFFFFF; e = 28'hFED_C345;
    put(grp(v, e, 1) + 32, mk0(1, v, e, 1), mk1(20'h9ABCD, 0, 1, 2'd1));
    run("T10", v, 0, 1, 0, e, 1, 0, 0);

    // R4: two matches in one group, the lower one wins
    mem.delete();
    tbl_base = 32'h0010_0000; tbl_mask = 32'h000F_FFC0;
    v = 24'h246802; e = 28'h135_7246;
    put(grp(v, e, 0) + 16, mk0(1, v, e, 0), mk1(20'hAAAAA, 1, 1, 2'd2));
    put(grp(v, e, 0) + 48, mk0(1, v, e, 0), mk1(20'hBBBBB, 1, 1, 2'd2));
    run("T11", v, 0, 0, 0, e, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule